// File: doc/BRIEF.md
# System Control and Status Register

A single-address register block that presents two different words at the same location. A write loads a control word. The control word drives an active-low LED field, a serial-driver disable, a memory parity-check disable and a self-test pass flag. A read returns a status word. The status word reports two sticky event bits, mirrors of the three single-bit controls, three sampled comparator results and two live board inputs.

The two sticky bits are a video-region event, set by a pulse from region detector 2, and a memory error, set when a bus write times out. Together they drive one shared, registered, active-high interrupt line. Software clears either bit by writing a one into its position; a zero leaves it alone. The three colour-comparator inputs are sampled only in cycles where region detector 1 pulses, so the readout is stable between strobes. All accesses are 16 bits wide, and the block has no address decode.

Top module: `sysctl_csr`

## Requirements
- R1: After reset the control word is all zero, so `ledN` is all zero (every LED lit), `txDisable`, `parityDisable` and `selfTestPass` are 0, both sticky bits and the three comparator bits read 0, and `irq` is 0.
- R2: A clock edge with `wrEn` high loads `ledN` from `wrData[15:12]`, `txDisable` from `wrData[2]`, `parityDisable` from `wrData[3]` and `selfTestPass` from `wrData[4]`. The new values are visible after that edge. Without `wrEn` the controls hold.
- R3: `rdData[2]`, `rdData[3]` and `rdData[4]` mirror `txDisable`, `parityDisable` and `selfTestPass`.
- R4: A clock edge with `region2Pulse` high sets the video bit `rdData[0]`. A clock edge with `busWrTimeout` high sets the memory-error bit `rdData[1]`. Each bit stays set after its source returns low.
- R5: A write with `wrData[0]` = 1 clears `rdData[0]`, and a write with `wrData[1]` = 1 clears `rdData[1]`. A write with a 0 in either position leaves that bit unchanged.
- R6: If a set event and a clear write hit the same sticky bit at the same edge, the bit ends set.
- R7: `irq` is high exactly in the cycle after either sticky bit is 1, and low in the cycle after both are 0.
- R8: `rdData[7]` (red over blue), `rdData[8]` (red over green) and `rdData[9]` (blue over green) take `cmpRgtB`, `cmpRgtG` and `cmpBgtG` at a clock edge with `region1Pulse` high. At any other edge they hold.
- R9: `rdData[5]` shows `cursorTest` and `rdData[6]` shows `mfgJumper` combinationally. `rdData[15:10]` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 16 | Control word to write |
| rdData | output | 16 | Status word |
| region1Pulse | input | 1 | Region detector 1 output; comparator sample strobe |
| region2Pulse | input | 1 | Region detector 2 output; sets the video bit |
| busWrTimeout | input | 1 | Bus write timeout; sets the memory-error bit |
| cmpRgtB | input | 1 | Comparator: red above blue |
| cmpRgtG | input | 1 | Comparator: red above green |
| cmpBgtG | input | 1 | Comparator: blue above green |
| cursorTest | input | 1 | External cursor test flip-flop state |
| mfgJumper | input | 1 | Manufacturing-mode jumper |
| ledN | output | 4 | LED drive, active low |
| txDisable | output | 1 | Serial driver disable |
| parityDisable | output | 1 | Parity checking disable |
| selfTestPass | output | 1 | Self-test pass flag |
| irq | output | 1 | Shared interrupt, active high |

## Verification
The assertions assume the event and strobe inputs are clean synchronous levels, sampled once per clock edge. They also assume that a write may coincide with any event. The bench drives every input at the falling edge only and holds it for a full cycle. It walks every control-bit combination, and every pairing of set and clear with each starting value of the two sticky bits. It also covers every comparator pattern, both with and without the strobe.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int VID_POS  = 0;
  localparam int MEM_POS  = 1;
  localparam int TX_POS   = 2;
  localparam int PAR_POS  = 3;
  localparam int PASS_POS = 4;
  localparam int CT_POS   = 5;
  localparam int JMP_POS  = 6;
  localparam int CMP_LSB  = 7;
  localparam int CMP_W    = 3;

  typedef struct packed {
    logic ctrlLoad;
    logic clrVid;
    logic clrMem;
    logic setVid;
    logic setMem;
    logic cmpLoad;
  } strobe_t;
endpackage

// File: rtl/sysctl_ctrl.sv
module sysctl_ctrl
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              region1Pulse,
  input  logic              region2Pulse,
  input  logic              busWrTimeout,
  output strobe_t           strobe
);
  always_comb begin
    strobe.ctrlLoad = wrEn;
    strobe.clrVid   = wrEn && wrData[VID_POS];
    strobe.clrMem   = wrEn && wrData[MEM_POS];
    strobe.setVid   = region2Pulse;
    strobe.setMem   = busWrTimeout;
    strobe.cmpLoad  = region1Pulse;
  end
endmodule

// File: rtl/sysctl_dp.sv
module sysctl_dp
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LED_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CMP_W-1:0]  cmpIn,
  input  logic              cursorTest,
  input  logic              mfgJumper,
  output logic [DATA_W-1:0] rdData,
  output logic [LED_W-1:0]  ledN,
  output logic              txDisable,
  output logic              parityDisable,
  output logic              selfTestPass,
  output logic              irq
);
  localparam int LED_LSB = DATA_W - LED_W;

  logic [LED_W-1:0] ledReg;
  logic             txReg, parReg, passReg;
  logic             vidReg, memReg, irqReg;
  logic [CMP_W-1:0] cmpReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ledReg  <= '0;
      txReg   <= 1'b0;
      parReg  <= 1'b0;
      passReg <= 1'b0;
    end else if (strobe.ctrlLoad) begin
      ledReg  <= wrData[LED_LSB +: LED_W];
      txReg   <= wrData[TX_POS];
      parReg  <= wrData[PAR_POS];
      passReg <= wrData[PASS_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidReg <= 1'b0;
      memReg <= 1'b0;
      irqReg <= 1'b0;
    end else begin
      vidReg <= strobe.setVid | (vidReg & ~strobe.clrVid);
      memReg <= strobe.setMem | (memReg & ~strobe.clrMem);
      irqReg <= vidReg | memReg;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cmpReg <= '0;
    else if (strobe.cmpLoad) cmpReg <= cmpIn;
  end

  always_comb begin
    rdData                    = '0;
    rdData[VID_POS]           = vidReg;
    rdData[MEM_POS]           = memReg;
    rdData[TX_POS]            = txReg;
    rdData[PAR_POS]           = parReg;
    rdData[PASS_POS]          = passReg;
    rdData[CT_POS]            = cursorTest;
    rdData[JMP_POS]           = mfgJumper;
    rdData[CMP_LSB +: CMP_W]  = cmpReg;
  end

  assign ledN          = ledReg;
  assign txDisable     = txReg;
  assign parityDisable = parReg;
  assign selfTestPass  = passReg;
  assign irq           = irqReg;

  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setVid |=> rdData[VID_POS]);
  p_clear_mem_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrMem && !strobe.setMem) |=> !rdData[MEM_POS]);
  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[VID_POS] || rdData[MEM_POS]) |=> irq);
  p_irq_drops_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!rdData[VID_POS] && !rdData[MEM_POS]) |=> !irq);
  p_cmp_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.cmpLoad |=> $stable(rdData[CMP_LSB +: CMP_W]));
  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.ctrlLoad |=> ($stable(ledN) && $stable(txDisable)));
endmodule

// File: rtl/sysctl_csr.sv
module sysctl_csr
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LED_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              region1Pulse,
  input  logic              region2Pulse,
  input  logic              busWrTimeout,
  input  logic              cmpRgtB,
  input  logic              cmpRgtG,
  input  logic              cmpBgtG,
  input  logic              cursorTest,
  input  logic              mfgJumper,
  output logic [LED_W-1:0]  ledN,
  output logic              txDisable,
  output logic              parityDisable,
  output logic              selfTestPass,
  output logic              irq
);
  strobe_t strobe;

  sysctl_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .region1Pulse(region1Pulse),
    .region2Pulse(region2Pulse), .busWrTimeout(busWrTimeout), .strobe(strobe)
  );

  sysctl_dp #(.DATA_W(DATA_W), .LED_W(LED_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cmpIn({cmpBgtG, cmpRgtG, cmpRgtB}), .cursorTest(cursorTest),
    .mfgJumper(mfgJumper), .rdData(rdData), .ledN(ledN),
    .txDisable(txDisable), .parityDisable(parityDisable),
    .selfTestPass(selfTestPass), .irq(irq)
  );
endmodule

// File: tb/sim_sysctl_csr.sv
module sim_sysctl_csr;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic r1 = 0, r2 = 0, bto = 0, cRB = 0, cRG = 0, cBG = 0, ct = 0, jmp = 0;
  logic [3:0] ledN;
  logic txD, parD, pass, irq;
  int vectors = 0, errors = 0;

  logic [3:0] eLed = '0;
  logic eTx = 0, ePar = 0, ePass = 0, eVid = 0, eMem = 0;
  logic [2:0] eCmp = '0;

  always #4 clk = ~clk;

  sysctl_csr u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .region1Pulse(r1), .region2Pulse(r2), .busWrTimeout(bto),
    .cmpRgtB(cRB), .cmpRgtG(cRG), .cmpBgtG(cBG), .cursorTest(ct),
    .mfgJumper(jmp), .ledN(ledN), .txDisable(txD), .parityDisable(parD),
    .selfTestPass(pass), .irq(irq)
  );

  function automatic logic [15:0] expStatus();
    return {6'b0, eCmp, jmp, ct, ePass, ePar, eTx, eMem, eVid};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    check(req, rdData, expStatus());
    check(req, {ledN, txD, parD, pass}, {eLed, eTx, ePar, ePass});
  endtask

  // one clock: apply stimulus now (after negedge), update model, compare at next negedge
  task automatic cycle(logic w, logic [15:0] d, logic p1, logic p2, logic t,
                       logic [2:0] c, string req);
    logic prevIrq;
    wrEn = w; wrData = d; r1 = p1; r2 = p2; bto = t; {cBG, cRG, cRB} = c;
    prevIrq = eVid | eMem;
    @(posedge clk);
    @(negedge clk);
    if (w) begin
      eLed = d[15:12]; eTx = d[2]; ePar = d[3]; ePass = d[4];
    end
    eVid = p2 | (eVid & ~(w & d[0]));
    eMem = t  | (eMem & ~(w & d[1]));
    if (p1) eCmp = c;
    wrEn = 0; r1 = 0; r2 = 0; bto = 0;
    checkAll(req);
    check("R7 irq", irq, prevIrq);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    checkAll("R1 reset");
    check("R1 irq", irq, 0);
    check("R1 ledN lit", ledN, 4'h0);

    // R2/R3 control sweep, also writing 0 to sticky positions
    for (int i = 0; i < 128; i++) begin
      logic [15:0] d;
      d = {i[6:3], 7'b0, i[2:0], 2'b00};
      cycle(1, d, 0, 0, 0, 3'b0, "R2 R3 ctrl load");
    end
    // R2 hold without write
    cycle(0, 16'hFFFF, 0, 0, 0, 3'b0, "R2 hold");

    // R4 R5 R6 sticky sweep: start state x event x clear, for both bits
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 2; s++)
        for (int e = 0; e < 2; e++)
          for (int c = 0; c < 2; c++) begin
            logic [15:0] d;
            // establish start state
            cycle(1, 16'h0003, 0, 0, 0, 3'b0, "R5 clear both");
            cycle(0, '0, 0, 0, 0, 3'b0, "R7 idle");
            if (s) cycle(0, '0, 0, b == 0, b == 1, 3'b0, "R4 set");
            cycle(0, '0, 0, 0, 0, 3'b0, "R4 sticky holds");
            d = {eLed, 7'b0, ePass, ePar, eTx, 2'b00};
            d[b] = c[0];
            cycle(c[0], d, 0, (b == 0) && e[0], (b == 1) && e[0], 3'b0,
                  "R5 R6 set/clear");
            cycle(0, '0, 0, 0, 0, 3'b0, "R7 irq after");
          end

    // R8 comparator sweep with and without strobe
    for (int i = 0; i < 16; i++) begin
      cycle(0, '0, i[3], 0, 0, i[2:0], "R8 comparator");
      cycle(0, '0, 0, 0, 0, ~i[2:0], "R8 hold");
    end

    // R9 live inputs
    for (int i = 0; i < 4; i++) begin
      ct = i[0]; jmp = i[1];
      #1;
      checkAll("R9 live inputs");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule